// File: doc/BRIEF.md
# Single-PHY UTOPIA Cell Transmitter

This block is the transmit end of a UTOPIA Level 2 bus master serving one PHY. An internal source presents ATM cell bytes one at a time with a valid/ready handshake. The block forwards each accepted byte to the PHY on an 8-bit bus one cycle later. It drives an active-low enable for every byte on the bus and a start-of-cell strobe on the first byte of each 53-byte cell. Because only one PHY is attached, the PHY address output is held at all ones.

The PHY reports room through a single flag, `phy_room`. A mode input selects between two flow-control schemes. In cell-level mode the flag is read only between cells: a cell may begin only while the flag is high, and once it has begun it runs to the end. In octet-level mode the flag is read on every byte. After it falls, the PHY still takes up to four more bytes, and the block must hold off from then until the flag rises again.

Top module: `utx_sphy_tx`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `phy_enb_n` is 1 and `phy_soc` is 0. The byte counter starts at zero, so the first byte accepted after reset carries `phy_soc`.
- R2: `phy_addr` is all ones at all times.
- R3: In cell-level mode (`octet_mode`=0) on a cell boundary, `src_ready` equals `phy_room`.
- R4: In cell-level mode, once a cell's first byte has been accepted, `src_ready` stays 1 until its 53rd byte has been accepted, whatever `phy_room` does.
- R5: A byte is accepted in a cycle where `src_valid` and `src_ready` are both 1. In the next cycle `phy_enb_n` is 0 and `phy_data` equals that byte. In every other cycle `phy_enb_n` is 1.
- R6: `phy_soc` is 1 exactly on the bus cycle carrying byte 0 of a cell, counting accepted bytes modulo 53 since reset, in either mode.
- R7: In octet-level mode (`octet_mode`=1), `src_ready` is 1 whenever `phy_room` is 1.
- R8: In octet-level mode, while `phy_room` stays 0, at most four bytes are accepted. After the fourth, `src_ready` is 0 until `phy_room` rises.
- R9: In octet-level mode, a cycle with `phy_room`=1 restores the full allowance of four bytes for the next time the flag falls. Cell-level mode also restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| octet_mode | input | 1 | 0 = cell-level, 1 = octet-level flow control |
| phy_room | input | 1 | PHY flag: 1 = can accept (cell or bytes) |
| src_valid | input | 1 | Source byte valid |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block accepts the source byte this cycle |
| phy_data | output | 8 | Byte driven to the PHY |
| phy_enb_n | output | 1 | Active-low transmit enable |
| phy_soc | output | 1 | Start-of-cell strobe, with byte 0 |
| phy_addr | output | 5 | PHY address, all ones |

## Verification
The byte counter has no port of its own, so a counter that is off by one only shows as a misplaced `phy_soc`. That error surfaces at the next cell boundary, up to 53 accepted bytes later. The same counter decides when a cell-level cell may stop, so a counter error also shows in cell-level mode as `src_ready` dropping mid-cell or staying high on a boundary while `phy_room` is low. A wrong grace count shows within four bytes of `phy_room` falling in octet-level mode, as a fifth accepted byte or an early stall.

// File: rtl/utx_pkg.sv
package utx_pkg;
  // Byte index after one accepted byte, wrapping at the cell length.
  function automatic int unsigned cell_next(int unsigned cur, int unsigned len);
    return (cur + 1 >= len) ? 0 : cur + 1;
  endfunction

  // Remaining grace bytes after a cycle in octet-level flow control.
  function automatic int unsigned grace_next(int unsigned cur, int unsigned full_allow,
                                             logic reload, logic take);
    if (reload) return full_allow;
    if (take && cur != 0) return cur - 1;
    return cur;
  endfunction
endpackage

// File: rtl/utx_cell_counter.sv
module utx_cell_counter #(
  parameter int CELL_LEN = 53
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic at_first
);
  import utx_pkg::*;
  localparam int CW = $clog2(CELL_LEN);

  logic [CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (fire) idx_q <= CW'(cell_next(int'(idx_q), CELL_LEN));
  end

  assign at_first = (idx_q == '0);

  // R6: index never leaves the cell range
  a_r6_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < CELL_LEN);
endmodule

// File: rtl/utx_flow_gate.sv
module utx_flow_gate #(
  parameter int GRACE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic octet_mode,
  input  logic phy_room,
  input  logic at_first,
  input  logic fire,
  output logic permit
);
  import utx_pkg::*;
  localparam int GW = $clog2(GRACE + 1);

  logic [GW-1:0] grace_q;
  logic          reload;
  logic          cell_ok;
  logic          octet_ok;

  assign reload   = phy_room || !octet_mode;
  assign cell_ok  = !at_first || phy_room;
  assign octet_ok = phy_room || (grace_q != '0);
  assign permit   = octet_mode ? octet_ok : cell_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) grace_q <= GW'(GRACE);
    else grace_q <= GW'(grace_next(int'(grace_q), GRACE, reload, fire));
  end

  // R9: a cycle with room (or cell-level mode) leaves the full allowance
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> int'(grace_q) == GRACE);
  // R8: allowance only drops by one per accepted byte
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !fire) |=> $stable(grace_q));
endmodule

// File: rtl/utx_bus_driver.sv
module utx_bus_driver #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          first,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] phy_data,
  output logic          phy_enb_n,
  output logic          phy_soc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_data  <= '0;
      phy_enb_n <= 1'b1;
      phy_soc   <= 1'b0;
    end else begin
      phy_enb_n <= !fire;
      phy_soc   <= fire && first;
      if (fire) phy_data <= data_in;
    end
  end

  // R6: start-of-cell only on a live bus cycle
  a_r6_soc_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    phy_soc |-> !phy_enb_n);
  // R5: the bus carries the accepted byte in the following cycle
  a_r5_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (phy_data == $past(data_in)));
endmodule

// File: rtl/utx_sphy_tx.sv
module utx_sphy_tx #(
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int CELL_LEN = 53,
  parameter int GRACE    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          octet_mode,
  input  logic          phy_room,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  output logic [DW-1:0] phy_data,
  output logic          phy_enb_n,
  output logic          phy_soc,
  output logic [AW-1:0] phy_addr
);
  localparam int GCW = $clog2(GRACE + 2);

  logic fire;
  logic at_first;
  logic permit;

  assign src_ready = permit;
  assign fire      = src_valid && permit;
  assign phy_addr  = '1;

  utx_cell_counter #(.CELL_LEN(CELL_LEN)) u_count (
    .clk(clk), .rst_n(rst_n), .fire(fire), .at_first(at_first)
  );

  utx_flow_gate #(.GRACE(GRACE)) u_gate (
    .clk(clk), .rst_n(rst_n), .octet_mode(octet_mode), .phy_room(phy_room),
    .at_first(at_first), .fire(fire), .permit(permit)
  );

  utx_bus_driver #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .fire(fire), .first(at_first),
    .data_in(src_data), .phy_data(phy_data), .phy_enb_n(phy_enb_n), .phy_soc(phy_soc)
  );

  // Independent tally of bytes taken while the PHY reports full.
  logic [GCW-1:0] full_takes_q;
  always_ff @(posedge clk) begin
    if (!rst_n || phy_room || !octet_mode) full_takes_q <= '0;
    else if (fire && int'(full_takes_q) <= GRACE) full_takes_q <= full_takes_q + 1'b1;
  end

  // R8: no fifth byte while full
  a_r8_grace_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (octet_mode && !phy_room && fire) |-> int'(full_takes_q) < GRACE);
  // R5: enable follows acceptance by one cycle
  a_r5_enb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !phy_enb_n);
  a_r5_enb_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> phy_enb_n);
  // R4: mid-cell in cell-level mode the source is never held off
  a_r4_cell_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!octet_mode && !at_first) |-> src_ready);
  // R7: octet-level mode with room is always ready
  a_r7_room_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (octet_mode && phy_room) |-> src_ready);
endmodule

// File: tb/utx_sphy_tx_tb.sv
module utx_sphy_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       octet_mode = 1'b0;
  logic       phy_room = 1'b0;
  logic       src_valid = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic       src_ready;
  logic [7:0] phy_data;
  logic       phy_enb_n;
  logic       phy_soc;
  logic [4:0] phy_addr;

  always #2 clk = ~clk;  // 250 MHz

  utx_sphy_tx u_dut (
    .clk(clk), .rst_n(rst_n), .octet_mode(octet_mode), .phy_room(phy_room),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .phy_data(phy_data), .phy_enb_n(phy_enb_n), .phy_soc(phy_soc), .phy_addr(phy_addr)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  int       m_idx;
  int       m_grace;
  logic     e_enb;
  logic     e_soc;
  logic [7:0] e_data;
  logic [7:0] nxt_byte = 8'h10;
  int       enb_lows;
  int       soc_seen;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_valid = 1'b0; phy_room = 1'b0; octet_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(phy_enb_n === 1'b1, "R1 enb in reset", int'(phy_enb_n), 1);
    chk(phy_soc === 1'b0, "R1 soc in reset", int'(phy_soc), 0);
    rst_n = 1'b1;
    m_idx = 0; m_grace = 4; e_enb = 1'b1; e_soc = 1'b0; e_data = 8'h00;
  endtask

  task automatic step(input logic mode, input logic room, input logic valid);
    logic er;
    logic fire;
    string tag;
    @(negedge clk);
    chk(phy_enb_n === e_enb, "R5 enable", int'(phy_enb_n), int'(e_enb));
    if (!e_enb) chk(phy_data === e_data, "R5 data", int'(phy_data), int'(e_data));
    chk(phy_soc === e_soc, "R6 soc", int'(phy_soc), int'(e_soc));
    chk(phy_addr === 5'h1F, "R2 addr", int'(phy_addr), 31);
    if (!phy_enb_n) enb_lows++;
    if (phy_soc) soc_seen++;
    octet_mode = mode; phy_room = room; src_valid = valid; src_data = nxt_byte;
    #1;
    if (mode) begin
      er  = room || (m_grace != 0);
      tag = room ? "R7 ready" : "R8 ready";
    end else begin
      er  = (m_idx != 0) || room;
      tag = (m_idx != 0) ? "R4 ready" : "R3 ready";
    end
    chk(src_ready === er, tag, int'(src_ready), int'(er));
    fire  = valid && er;
    e_enb = !fire;
    e_soc = fire && (m_idx == 0);
    e_data = nxt_byte;
    if (fire) begin
      m_idx = (m_idx == 52) ? 0 : m_idx + 1;
      nxt_byte = nxt_byte + 8'd7;
    end
    if (room || !mode) m_grace = 4;
    else if (fire && m_grace != 0) m_grace--;
  endtask

  // phases: {octet_mode, phy_room, src_valid, cycles[7:0]}
  localparam int NPH = 14;
  localparam logic [10:0] PH [NPH] = '{
    {3'b011, 8'd60}, {3'b001, 8'd60}, {3'b001, 8'd5},  {3'b010, 8'd5},
    {3'b011, 8'd10}, {3'b001, 8'd50}, {3'b111, 8'd20}, {3'b101, 8'd8},
    {3'b111, 8'd3},  {3'b101, 8'd2},  {3'b100, 8'd3},  {3'b101, 8'd5},
    {3'b110, 8'd2},  {3'b101, 8'd6}
  };

  initial begin
    do_reset();
    // R1: first accepted byte after reset is a start of cell
    soc_seen = 0;
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    chk(soc_seen == 1, "R1 first byte soc", soc_seen, 1);

    do_reset();
    for (int p = 0; p < NPH; p++) begin
      for (int c = 0; c < int'(PH[p][7:0]); c++)
        step(PH[p][10], PH[p][9], PH[p][8]);
    end
    step(1'b0, 1'b0, 1'b0);

    // R8: exactly four bytes while full
    do_reset();
    step(1'b1, 1'b1, 1'b0);
    enb_lows = 0;
    for (int c = 0; c < 10; c++) step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    chk(enb_lows == 4, "R8 grace count", enb_lows, 4);
    // R9: room restores allowance
    step(1'b1, 1'b1, 1'b0);
    enb_lows = 0;
    for (int c = 0; c < 8; c++) step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    chk(enb_lows == 4, "R9 allowance restored", enb_lows, 4);

    // R4: whole cell despite room dropping after start
    do_reset();
    step(1'b0, 1'b1, 1'b1);
    enb_lows = 0; soc_seen = 0;
    for (int c = 0; c < 70; c++) step(1'b0, 1'b0, 1'b1);
    chk(enb_lows == 53, "R4 full cell bytes", enb_lows, 53);
    chk(soc_seen == 1, "R6 one soc per cell", soc_seen, 1);

    // R3: no start without room
    enb_lows = 0;
    for (int c = 0; c < 6; c++) step(1'b0, 1'b0, 1'b1);
    chk(enb_lows == 0, "R3 no start", enb_lows, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule